// File: doc/BRIEF.md
# Multichannel Audio Sample Buffer

This block gathers 16-bit samples from several audio channels and keeps each channel's samples in a separate circular buffer. An ADC-side front end hands in one sample at a time with a channel index and a valid strobe. A host processor drains the buffers over a small address/data read port. Each channel has its own read address, and every read of that address removes the oldest sample that channel holds.

Each buffer holds 512 samples. All the buffers share one memory that is indexed by channel and pointer, so the storage maps onto block RAM. Once a channel's buffer is at least half full, that channel's pending bit is set and the host interrupt goes high. The host can read the fill level of each channel to size its burst. Sticky overflow and underflow flags record lost samples and empty reads. Reading a flag register returns the flags and clears them. Everything runs on one clock and uses a synchronous active-high reset.

Top module: `audio_capture_buf`

## Requirements
- R1: While `rst` is high at a clock edge, every buffer becomes empty, every pending, overflow and underflow flag clears, and `irq` and `rd_valid` go low after that edge.
- R2: A read with `rd_en` high at addresses 0 to 7 pops the oldest sample of channel `rd_addr[2:0]`. The sample appears on `rd_data` with `rd_valid` high after the next clock edge. Repeated reads return the samples in arrival order.
- R3: The channels are independent: a write or read of one channel never changes another channel's contents, order or level.
- R4: A sample written to a channel that already holds 512 samples is dropped, and bit c of the overflow register (address 17) is set.
- R5: A sample read from an empty channel returns 0, leaves that channel's contents unchanged, and sets bit c of the underflow register (address 18).
- R6: A read at address 8+c returns channel c's level, 0 to 512, as it was before that clock edge's write and pop.
- R7: Bit c of the pending register (address 16) is 1 exactly when channel c holds 256 or more samples. `irq` is the OR of the pending bits, and both update on the same edge as the level.
- R8: A read of the overflow or underflow register returns the flags held before that edge and then clears them. An event in the same cycle still sets its flag.
- R9: When a write and a pop hit the same channel in one cycle, the full test uses the level before that edge. A full channel therefore drops the new sample, even though a pop happens on the same edge.
- R10: A read at any address from 19 to 31 returns 0 with `rd_valid` high and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe from the ADC side |
| smp_chan | input | 3 | Channel index of the incoming sample |
| smp_data | input | 16 | Incoming sample value |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 5 | Host read address |
| rd_data | output | 16 | Read result, valid one cycle after `rd_en` |
| rd_valid | output | 1 | High when `rd_data` holds a read result |
| irq | output | 1 | OR of the per-channel pending bits |

## Verification
A wrong pointer or level shows up at the ports within one read. It appears as a sample returned out of order, a level that disagrees with the count of writes minus pops, or a pending bit or `irq` that changes on the wrong edge. The bench keeps one queue per channel and compares `rd_data`, `rd_valid` and `irq` on every clock. Any divergence in the internal state is therefore reported on the first read that touches it, and a level crossing half full is reported on the cycle it happens. Directed phases fill a channel past its capacity, read empty channels, and push and pop a full channel in the same cycle. Long mixed traffic then checks that the channels stay independent.

// File: rtl/acb_pkg.sv
package acb_pkg;
  // Upper address bits select a region of the host read map.
  typedef enum logic [1:0] {
    RG_SMP  = 2'd0,
    RG_LVL  = 2'd1,
    RG_STAT = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  // Offsets inside the status region.
  localparam int unsigned ST_PEND = 0;
  localparam int unsigned ST_OVF  = 1;
  localparam int unsigned ST_UDF  = 2;
endpackage

// File: rtl/acb_sample_ram.sv
module acb_sample_ram #(
  parameter int unsigned DW    = 16,
  parameter int unsigned WORDS = 4096,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/acb_ring_ctl.sv
module acb_ring_ctl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic [LW-1:0] level_nxt,
  output logic          full,
  output logic          empty
);
  logic take_in, take_out;

  assign full     = (level == LW'(DEPTH));
  assign empty    = (level == '0);
  assign take_in  = push && !full;
  assign take_out = pop && !empty;

  always_comb begin
    level_nxt = level;
    if (take_in && !take_out)      level_nxt = level + 1'b1;
    else if (take_out && !take_in) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (take_in)  wptr <= wptr + 1'b1;
      if (take_out) rptr <= rptr + 1'b1;
      level <= level_nxt;
    end
  end

  // R4
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> ($stable(level) && $stable(wptr)));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push) |=> ($stable(rptr) && level == '0));

  // R4
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
endmodule

// File: rtl/audio_capture_buf.sv
module audio_capture_buf #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned CW   = $clog2(NCH),
  localparam int unsigned AW   = CW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [CW-1:0] smp_chan,
  input  logic [DW-1:0] smp_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          irq
);
  import acb_pkg::*;

  localparam int unsigned PW   = $clog2(DEPTH);
  localparam int unsigned LW   = PW + 1;
  localparam int unsigned HALF = DEPTH / 2;
  localparam int unsigned MA   = CW + PW;

  region_e       rg;
  logic [CW-1:0] rd_ch;
  logic          is_smp;

  logic [PW-1:0]  wptr [NCH];
  logic [PW-1:0]  rptr [NCH];
  logic [LW-1:0]  lvl  [NCH];
  logic [LW-1:0]  lvl_n[NCH];
  logic [NCH-1:0] full, empty, push_v, pop_v, pend_n;

  logic [NCH-1:0] pend_q, ovf_q, udf_q;
  logic           clr_ovf, clr_udf;
  logic [DW-1:0]  mem_q, reg_q;
  logic           sel_reg_q;

  assign rg     = region_e'(rd_addr[AW-1:CW]);
  assign rd_ch  = rd_addr[CW-1:0];
  assign is_smp = rd_en && (rg == RG_SMP);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign push_v[c] = smp_valid && (smp_chan == CW'(c));
      assign pop_v[c]  = is_smp && (rd_ch == CW'(c));
      assign pend_n[c] = (lvl_n[c] >= LW'(HALF));

      acb_ring_ctl #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (push_v[c]),
        .pop      (pop_v[c]),
        .wptr     (wptr[c]),
        .rptr     (rptr[c]),
        .level    (lvl[c]),
        .level_nxt(lvl_n[c]),
        .full     (full[c]),
        .empty    (empty[c])
      );
    end
  endgenerate

  acb_sample_ram #(.DW(DW), .WORDS(NCH * DEPTH)) u_ram (
    .clk  (clk),
    .we   (smp_valid && !full[smp_chan]),
    .waddr(MA'({smp_chan, wptr[smp_chan]})),
    .wdata(smp_data),
    .re   (is_smp && !empty[rd_ch]),
    .raddr(MA'({rd_ch, rptr[rd_ch]})),
    .rdata(mem_q)
  );

  assign clr_ovf = rd_en && (rg == RG_STAT) && (rd_ch == CW'(ST_OVF));
  assign clr_udf = rd_en && (rg == RG_STAT) && (rd_ch == CW'(ST_UDF));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= '0;
      ovf_q     <= '0;
      udf_q     <= '0;
      irq       <= 1'b0;
      rd_valid  <= 1'b0;
      sel_reg_q <= 1'b1;
      reg_q     <= '0;
    end else begin
      pend_q   <= pend_n;
      irq      <= |pend_n;
      ovf_q    <= (clr_ovf ? '0 : ovf_q) | (push_v & full);
      udf_q    <= (clr_udf ? '0 : udf_q) | (pop_v & empty);
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_reg_q <= !(is_smp && !empty[rd_ch]);
        reg_q     <= '0;
        unique case (rg)
          RG_LVL:  reg_q <= DW'(lvl[rd_ch]);
          RG_STAT: begin
            if (rd_ch == CW'(ST_PEND))     reg_q <= DW'(pend_q);
            else if (rd_ch == CW'(ST_OVF)) reg_q <= DW'(ovf_q);
            else if (rd_ch == CW'(ST_UDF)) reg_q <= DW'(udf_q);
          end
          default: reg_q <= '0;
        endcase
      end
    end
  end

  assign rd_data = sel_reg_q ? reg_q : mem_q;

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(smp_valid));

  // R7
  irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(rd_en));

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovf_q & ~$past(ovf_q)) != '0) |-> $past(smp_valid));

  // R5
  udf_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((udf_q & ~$past(udf_q)) != '0) |-> $past(is_smp));
endmodule

// File: tb/tb_audio_capture_buf.sv
module tb_audio_capture_buf;
  localparam int NCH = 8, DEPTH = 512, HALF = 256;

  logic        clk = 0;
  logic        rst = 1;
  logic        smp_valid = 0;
  logic [2:0]  smp_chan = 0;
  logic [15:0] smp_data = 0;
  logic        rd_en = 0;
  logic [4:0]  rd_addr = 0;
  logic [15:0] rd_data;
  logic        rd_valid, irq;

  audio_capture_buf dut (.*);

  always #5 clk = ~clk;

  int   n_chk = 0, n_fail = 0;
  int   q [NCH][$];
  bit   ovf [NCH], udf [NCH];
  bit   e_rv, e_irq;
  int   e_data;
  string e_tag;
  string phase = "R1";
  bit   armed = 0;

  // Behavioural reference, advanced on every clock
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin q[c].delete(); ovf[c] = 0; udf[c] = 0; end
      e_rv = 0; e_irq = 0; e_data = 0; e_tag = "R1";
    end else begin
      int old_sz [NCH];
      int a;
      for (int c = 0; c < NCH; c++) old_sz[c] = q[c].size();
      e_rv = rd_en;
      if (rd_en) begin
        a = rd_addr;
        e_data = 0;
        if (a < 8) begin
          e_tag = "R2";
          if (old_sz[a] > 0) e_data = q[a].pop_front();
          else begin udf[a] = 1; e_tag = "R5"; end
        end else if (a < 16) begin
          e_tag = "R6"; e_data = old_sz[a-8];
        end else if (a == 16) begin
          e_tag = "R7";
          for (int c = 0; c < NCH; c++) if (old_sz[c] >= HALF) e_data |= (1 << c);
        end else if (a == 17) begin
          e_tag = "R8";
          for (int c = 0; c < NCH; c++) begin if (ovf[c]) e_data |= (1 << c); ovf[c] = 0; end
        end else if (a == 18) begin
          e_tag = "R8";
          for (int c = 0; c < NCH; c++) begin if (udf[c]) e_data |= (1 << c); udf[c] = 0; end
        end else e_tag = "R10";
      end
      if (smp_valid) begin
        if (old_sz[smp_chan] < DEPTH) q[smp_chan].push_back(smp_data);
        else ovf[smp_chan] = 1;
      end
      e_irq = 0;
      for (int c = 0; c < NCH; c++) if (q[c].size() >= HALF) e_irq = 1;
    end
  end

  // Comparison away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      n_chk++;
      if (rd_valid !== e_rv) begin
        n_fail++; $display("FAIL R2/%s rd_valid got %0b exp %0b", phase, rd_valid, e_rv);
      end
      n_chk++;
      if (irq !== e_irq) begin
        n_fail++; $display("FAIL R7/%s irq got %0b exp %0b", phase, irq, e_irq);
      end
      if (e_rv) begin
        n_chk++;
        if (rd_data !== e_data[15:0]) begin
          n_fail++; $display("FAIL %s/%s rd_data got %0h exp %0h", e_tag, phase, rd_data, e_data[15:0]);
        end
      end
    end
  end

  task automatic cyc(input bit v, input int ch, input int d, input bit re, input int ra);
    @(negedge clk);
    smp_valid = v; smp_chan = ch[2:0]; smp_data = d[15:0];
    rd_en = re; rd_addr = ra[4:0];
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; armed = 1;
    // R1: levels, flags and pending all zero after reset
    phase = "R1";
    cyc(0,0,0,1,8); cyc(0,0,0,1,16); cyc(0,0,0,1,17); cyc(0,0,0,1,18);
    // R7: fill channel 0 across half, irq on the 256th write
    phase = "R7";
    for (int i = 0; i < 300; i++) cyc(1, 0, 16'h1000 + i, 0, 0);
    cyc(0,0,0,1,8); cyc(0,0,0,1,16);
    // R4: overfill channel 3
    phase = "R4";
    for (int i = 0; i < 520; i++) cyc(1, 3, 16'h3000 + i, 0, 0);
    cyc(0,0,0,1,11); cyc(0,0,0,1,17); cyc(0,0,0,1,17);
    // R9: push and pop on the full channel together
    phase = "R9";
    cyc(1, 3, 16'hBEEF, 1, 3); cyc(0,0,0,1,11); cyc(1, 3, 16'hCAFE, 1, 3); cyc(0,0,0,1,17);
    // R5: empty channel read
    phase = "R5";
    cyc(0,0,0,1,5); cyc(0,0,0,1,13); cyc(1, 5, 16'h0055, 1, 18); cyc(0,0,0,1,18); cyc(0,0,0,1,5);
    // R10: unmapped addresses
    phase = "R10";
    cyc(0,0,0,1,19); cyc(0,0,0,1,31); cyc(0,0,0,1,8);
    // R2: drain channel 0 past empty
    phase = "R2";
    for (int i = 0; i < 302; i++) cyc(0, 0, 0, 1, 0);
    cyc(0,0,0,1,16); cyc(0,0,0,1,18);
    // R3: mixed traffic on all channels
    phase = "R3";
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 3) != 0, $urandom % NCH, $urandom, ($urandom % 3) == 0, $urandom % 20);
    for (int c = 0; c < NCH; c++) cyc(0,0,0,1,8+c);
    // R1: reset mid-traffic clears everything
    phase = "R1";
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    cyc(0,0,0,1,11); cyc(0,0,0,1,17); cyc(0,0,0,1,16);
    cyc(0,0,0,0,0); cyc(0,0,0,0,0);
    finish_run();
  end
endmodule